// File: doc/BRIEF.md
# TDM Serial Transmit Highway with Shared-Line Receive

This block drives one serial time-division highway from byte-wide switched slot data. Each frame is cut into slots of eight bits. Before every slot begins, the block asks the switch for the byte of the following slot and keeps it in a one-byte holding register. It then shifts the byte out most significant bit first, at one of four selectable line rates. Each slot carries its own output-enable flag, so several transmitters can share one bused line. A programmable offset shifts the whole frame relative to the frame sync, in slots, bits and quarter bits.

All timing is taken from one block clock and a frame sync pulse. Each clock period is one quarter bit at the fastest rate, so one frame lasts 8192 clocks. In bidirectional mode the transmit pin is also the receive line. During slots the block does not drive, it samples the pin and returns the received bytes, and the dedicated receive input is then ignored. Outside bidirectional mode, the receive bytes come from the dedicated input.

Top module: `tdm_tx_highway`

## Requirements
- R1: `rate_sel` code k (0..3 = 2.048, 4.096, 8.192, 16.384 Mbit/s) gives `32<<k` slots per 8192-clock frame. One bit lasts `4<<(3-k)` clocks. Bits leave MSB first. The pins show the bit for the frame position the counter held one clock earlier.
- R2: A high `frame_sync` at a rising edge sets the frame position to 0. Otherwise the position advances by one per clock and wraps from 8191 to 0.
- R3: `offset` counts quarter bits at the selected rate. Bits [1:0] give the quarter, [4:2] give the bit and the upper bits give the slot. The local position is (frame position >> (3-k)) minus offset, modulo the frame length in quarter bits. Slot counts beyond the frame wrap. A bit starts at local quarter 0, so the quarter field picks the clock edge at which the output changes.
- R4: Offset resolution is half a bit, so `offset[0]` is ignored, when k=3 and also when k=2 with `refclk_slow`=1. In every other case, `offset[0]` shifts the output by one quarter bit.
- R5: At the first clock of local slot N, `req_valid` pulses for one clock with `req_slot` = (N+1) mod slot count. If `req_valid` is high in cycle c, the block captures `sw_byte` and `sw_oe` at the edge that ends cycle c+1.
- R6: For every clock of a slot, `txd_oe` equals that slot's `sw_oe`, including the bit periods that the offset moves. `txd_o` is 0 whenever `txd_oe` is low.
- R7: Outside bidirectional mode, `rxd_i` is sampled at quarter 2 of each bit and assembled MSB first. `rx_valid` pulses for one clock after bit 7, together with `rx_byte` and the local `rx_slot`.
- R8: With `bidir_en`=1, the receive data is taken from `txd_i` and `rxd_i` has no effect. No byte is reported for a slot the block is driving.
- R9: Reset clears all outputs. The output stays disabled until a byte has been staged for the current slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one quarter bit at the fastest rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Frame start pulse |
| rate_sel | input | 2 | Line rate code k |
| refclk_slow | input | 1 | 1 when the TDM reference clock is the slower of two |
| offset | input | 13 | Frame offset in quarter bits |
| bidir_en | input | 1 | Receive from the transmit pin |
| req_valid | output | 1 | Byte request strobe |
| req_slot | output | 8 | Slot whose byte is requested |
| sw_byte | input | 8 | Byte returned by the switch |
| sw_oe | input | 1 | Output enable for the requested slot |
| txd_o | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Transmit driver enable |
| txd_i | input | 1 | Level read back from the transmit pin |
| rxd_i | input | 1 | Dedicated receive input |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| rx_slot | output | 8 | Local slot of the received byte |

## Verification
Each rate runs with its own slot data and enable pattern: every slot enabled, alternate slots, every third slot off, or none enabled. Together these separate the bit timing, the MSB-first order and the per-slot enable from one another. One offset is run both where the quarter field counts and where it is dropped, so the half-bit rule shows as a two-clock shift. A slot offset larger than the frame checks the wrap. In bidirectional mode, different patterns go to the dedicated input and to the shared line. This shows which source is used, and that no bytes are reported for slots the block drives.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = 3;
    localparam int QTR_W  = 2;
    localparam int SUB_W  = BIT_W + QTR_W;

    // one staged or active slot: byte, its enable and a filled flag
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              oe;
        logic              vld;
    } slot_word_t;

    localparam slot_word_t SLOT_WORD_EMPTY = '0;

endpackage

// File: rtl/tdm_tx_timebase.sv
module tdm_tx_timebase
    import tdm_tx_pkg::*;
#(
    parameter int BASE_SLOT_LOG = 5,
    parameter int RATE_MAX      = 3,
    localparam int SLOT_W = BASE_SLOT_LOG + RATE_MAX,
    localparam int POS_W  = SLOT_W + SUB_W,
    localparam int RATE_W = $clog2(RATE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              refclk_slow,
    input  logic [POS_W-1:0]  offset,
    output logic [SLOT_W-1:0] slot_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic [SLOT_W-1:0] slot_mask_o,
    output logic              slot_start_o,
    output logic              sample_o,
    output logic              last_bit_o
);

    typedef struct packed {
        logic [POS_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    logic [RATE_W-1:0] shift;
    logic [POS_W-1:0]  sub_mask;
    logic [POS_W-1:0]  frame_mask;
    logic [POS_W-1:0]  off_eff;
    logic [POS_W-1:0]  qpos;
    logic [POS_W-1:0]  lpos;
    logic              half_res;
    logic              tick;

    always_comb begin
        st_d       = st_q;
        shift      = RATE_W'(RATE_MAX) - rate_sel;
        sub_mask   = ~({POS_W{1'b1}} << shift);
        frame_mask = {POS_W{1'b1}} >> shift;
        half_res   = (rate_sel == RATE_W'(RATE_MAX))
                  || ((rate_sel == RATE_W'(RATE_MAX - 1)) && refclk_slow);
        off_eff    = offset & ~{{(POS_W-1){1'b0}}, half_res};
        qpos       = st_q.cnt >> shift;
        lpos       = (qpos - off_eff) & frame_mask;
        tick       = (st_q.cnt & sub_mask) == '0;

        st_d.cnt   = frame_sync ? '0 : st_q.cnt + 1'b1;

        slot_o       = lpos[POS_W-1:SUB_W];
        bit_o        = lpos[SUB_W-1:QTR_W];
        slot_mask_o  = {SLOT_W{1'b1}} >> shift;
        slot_start_o = tick && (lpos[SUB_W-1:0] == '0);
        sample_o     = tick && (lpos[QTR_W-1:0] == QTR_W'(2));
        last_bit_o   = &lpos[SUB_W-1:QTR_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    fsync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (st_q.cnt == '0));

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot,
    input  logic [BIT_W-1:0]  bitn,
    input  logic [SLOT_W-1:0] slot_mask,
    input  logic              slot_start,
    input  logic [BYTE_W-1:0] sw_byte,
    input  logic              sw_oe,
    output logic              req_valid,
    output logic [SLOT_W-1:0] req_slot,
    output logic              txd_o,
    output logic              txd_oe,
    output logic              drive_o
);

    typedef struct packed {
        logic              req;
        logic              pend;
        logic [SLOT_W-1:0] req_slot;
        slot_word_t        stage;
        slot_word_t        cur;
        logic              out;
        logic              oe;
    } ser_state_t;

    ser_state_t s_d, s_q;
    slot_word_t eff;
    logic       en;

    always_comb begin
        s_d      = s_q;
        s_d.req  = slot_start;
        s_d.pend = s_q.req;
        if (slot_start) begin
            s_d.req_slot = (slot + 1'b1) & slot_mask;
            s_d.cur      = s_q.stage;
        end
        if (s_q.pend) begin
            s_d.stage.data = sw_byte;
            s_d.stage.oe   = sw_oe;
            s_d.stage.vld  = 1'b1;
        end
        // the slot that begins now takes its byte straight from the holding register
        eff     = slot_start ? s_q.stage : s_q.cur;
        en      = eff.vld && eff.oe;
        s_d.oe  = en;
        s_d.out = en && eff.data[3'd7 - bitn];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.stage <= SLOT_WORD_EMPTY;
            s_q.cur   <= SLOT_WORD_EMPTY;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid = s_q.req;
    assign req_slot  = s_q.req_slot;
    assign txd_o     = s_q.out;
    assign txd_oe    = s_q.oe;
    assign drive_o   = s_q.cur.vld && s_q.cur.oe;

    // R5
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R6
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> !txd_o);

    // R6
    oe_slot_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_oe != $past(txd_oe)) |-> $past(slot_start));

endmodule

// File: rtl/tdm_rx_sampler.sv
module tdm_rx_sampler
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              last_bit,
    input  logic [SLOT_W-1:0] slot,
    input  logic              bidir_en,
    input  logic              drive,
    input  logic              txd_i,
    input  logic              rxd_i,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [SLOT_W-1:0] rx_slot
);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              vld;
        logic [BYTE_W-1:0] byte_v;
        logic [SLOT_W-1:0] slot_v;
    } rx_state_t;

    rx_state_t r_d, r_q;
    logic      src;
    logic [BYTE_W-1:0] assembled;

    always_comb begin
        r_d       = r_q;
        r_d.vld   = 1'b0;
        src       = bidir_en ? txd_i : rxd_i;
        assembled = {r_q.sh[BYTE_W-2:0], src};
        if (sample) begin
            r_d.sh = assembled;
            if (last_bit && !(bidir_en && drive)) begin
                r_d.vld    = 1'b1;
                r_d.byte_v = assembled;
                r_d.slot_v = slot;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_valid = r_q.vld;
    assign rx_byte  = r_q.byte_v;
    assign rx_slot  = r_q.slot_v;

    // R7
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    bidir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bidir_en && drive && sample && last_bit) |=> !rx_valid);

endmodule

// File: rtl/tdm_tx_highway.sv
module tdm_tx_highway
    import tdm_tx_pkg::*;
#(
    parameter int BASE_SLOT_LOG = 5,
    parameter int RATE_MAX      = 3,
    localparam int SLOT_W = BASE_SLOT_LOG + RATE_MAX,
    localparam int POS_W  = SLOT_W + SUB_W,
    localparam int RATE_W = $clog2(RATE_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              refclk_slow,
    input  logic [POS_W-1:0]  offset,
    input  logic              bidir_en,
    output logic              req_valid,
    output logic [SLOT_W-1:0] req_slot,
    input  logic [BYTE_W-1:0] sw_byte,
    input  logic              sw_oe,
    output logic              txd_o,
    output logic              txd_oe,
    input  logic              txd_i,
    input  logic              rxd_i,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic [SLOT_W-1:0] rx_slot
);

    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bitn;
    logic [SLOT_W-1:0] slot_mask;
    logic              slot_start;
    logic              sample;
    logic              last_bit;
    logic              drive;

    tdm_tx_timebase #(
        .BASE_SLOT_LOG (BASE_SLOT_LOG),
        .RATE_MAX      (RATE_MAX)
    ) u_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync   (frame_sync),
        .rate_sel     (rate_sel),
        .refclk_slow  (refclk_slow),
        .offset       (offset),
        .slot_o       (slot),
        .bit_o        (bitn),
        .slot_mask_o  (slot_mask),
        .slot_start_o (slot_start),
        .sample_o     (sample),
        .last_bit_o   (last_bit)
    );

    tdm_tx_serializer #(
        .SLOT_W (SLOT_W)
    ) u_serializer (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot),
        .bitn       (bitn),
        .slot_mask  (slot_mask),
        .slot_start (slot_start),
        .sw_byte    (sw_byte),
        .sw_oe      (sw_oe),
        .req_valid  (req_valid),
        .req_slot   (req_slot),
        .txd_o      (txd_o),
        .txd_oe     (txd_oe),
        .drive_o    (drive)
    );

    tdm_rx_sampler #(
        .SLOT_W (SLOT_W)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .last_bit (last_bit),
        .slot     (slot),
        .bidir_en (bidir_en),
        .drive    (drive),
        .txd_i    (txd_i),
        .rxd_i    (rxd_i),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_slot  (rx_slot)
    );

endmodule

// File: tb/sim_tdm_tx_highway.sv
module sim_tdm_tx_highway;

    localparam int FRAME = 8192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic [1:0] rate_sel = 2'd3;
    logic       refclk_slow = 1'b0;
    logic [12:0] offset = '0;
    logic       bidir_en = 1'b0;
    logic       req_valid;
    logic [7:0] req_slot;
    logic [7:0] sw_byte = '0;
    logic       sw_oe = 1'b0;
    logic       txd_o, txd_oe, txd_i;
    logic       rxd_i = 1'b0;
    logic       ext_line = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic [7:0] rx_slot;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    int cfg_rate = 3, cfg_off = 0, cfg_mode = 0, cfg_key = 0;
    bit cfg_slow = 0, cfg_bidir = 0, chk_en = 0;
    int bc = 3000, prev_bc = 3000;
    int mism_tx, mism_req, mism_rx, req_cnt, rx_cnt;
    int tx_act, tx_exp, req_act, req_exp_v, rx_act, rx_exp_v;

    always #4 clk = ~clk;

    assign txd_i = txd_oe ? txd_o : ext_line;

    tdm_tx_highway u0 (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rate_sel(rate_sel),
        .refclk_slow(refclk_slow), .offset(offset), .bidir_en(bidir_en),
        .req_valid(req_valid), .req_slot(req_slot), .sw_byte(sw_byte), .sw_oe(sw_oe),
        .txd_o(txd_o), .txd_oe(txd_oe), .txd_i(txd_i), .rxd_i(rxd_i),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_slot(rx_slot)
    );

    function automatic int lpos(int c);
        int sh = 3 - cfg_rate;
        int qf = FRAME >> sh;
        bit half = (cfg_rate == 3) || (cfg_rate == 2 && cfg_slow);
        int o = half ? (cfg_off & ~1) : cfg_off;
        return ((c >> sh) - (o % qf) + qf) % qf;
    endfunction

    function automatic bit subfirst(int c);
        return (c & ((1 << (3 - cfg_rate)) - 1)) == 0;
    endfunction

    function automatic int data_pat(int s);
        return ((s * 37 + cfg_key * 11 + 5) ^ (s >> 2)) & 255;
    endfunction
    function automatic int rx_pat(int s);
        return (s * 53 + cfg_key + 60) & 255;
    endfunction
    function automatic int ext_pat(int s);
        return (~(s * 29 + cfg_key)) & 255;
    endfunction
    function automatic bit oe_pat(int s);
        case (cfg_mode)
            0: return 1'b1;
            1: return (s % 2) == 0;
            2: return 1'b0;
            default: return (s % 3) != 0;
        endcase
    endfunction

    always @(posedge clk) begin
        prev_bc <= bc;
        bc <= (frame_sync || bc == FRAME - 1) ? 0 : bc + 1;
    end

    always @(negedge clk) begin
        int l, s, b, n, l2, s2, b2, eo, eb, rsel;
        bit req_e, rx_e;
        l2 = lpos(bc); s2 = l2 >> 5; b2 = (l2 >> 2) & 7;
        rxd_i    = ((rx_pat(s2) >> (7 - b2)) & 1) != 0;
        ext_line = ((ext_pat(s2) >> (7 - b2)) & 1) != 0;
        frame_sync = (bc == FRAME - 1);
        if (req_valid) begin
            sw_byte = 8'(data_pat(int'(req_slot)));
            sw_oe   = oe_pat(int'(req_slot));
        end
        if (chk_en) begin
            l = lpos(prev_bc); s = l >> 5; b = (l >> 2) & 7;
            n = 32 << cfg_rate;
            eo = oe_pat(s) ? 1 : 0;
            eb = eo ? ((data_pat(s) >> (7 - b)) & 1) : 0;
            if (int'(txd_oe) != eo || int'(txd_o) != eb) begin
                if (mism_tx == 0) begin
                    tx_act = {txd_oe, txd_o}; tx_exp = eo * 2 + eb;
                end
                mism_tx++;
            end
            req_e = subfirst(prev_bc) && ((l & 31) == 0);
            if (req_valid) req_cnt++;
            if (req_valid != req_e || (req_e && int'(req_slot) != (s + 1) % n)) begin
                if (mism_req == 0) begin
                    req_act = req_valid ? int'(req_slot) : -1;
                    req_exp_v = req_e ? (s + 1) % n : -1;
                end
                mism_req++;
            end
            rx_e = subfirst(prev_bc) && ((l & 31) == 30) && !(cfg_bidir && oe_pat(s));
            rsel = cfg_bidir ? ext_pat(s) : rx_pat(s);
            if (rx_valid) rx_cnt++;
            if (rx_valid != rx_e ||
                (rx_e && (int'(rx_slot) != s || int'(rx_byte) != rsel))) begin
                if (mism_rx == 0) begin
                    rx_act = rx_valid ? int'(rx_byte) : -1;
                    rx_exp_v = rx_e ? rsel : -1;
                end
                mism_rx++;
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(int rate, int off, bit slow, bit bidir, int mode, int key);
        @(posedge clk);
        cfg_rate = rate; cfg_off = off; cfg_slow = slow; cfg_bidir = bidir;
        cfg_mode = mode; cfg_key = key; chk_en = 0;
        rate_sel = 2'(rate); offset = 13'(off); refclk_slow = slow; bidir_en = bidir;
        repeat (FRAME) @(posedge clk);
        mism_tx = 0; mism_req = 0; mism_rx = 0; req_cnt = 0; rx_cnt = 0;
        chk_en = 1;
        repeat (FRAME) @(posedge clk);
        chk_en = 0;
    endtask

    task automatic check_common(string tag);
        check(mism_tx == 0, "R1 R3 R6", {tag, " txd bits/enable ({oe,d})"}, tx_act, tx_exp);
        check(mism_req == 0, "R5", {tag, " request timing/slot"}, req_act, req_exp_v);
        check(req_cnt == (32 << cfg_rate), "R5", {tag, " requests per frame"},
              req_cnt, 32 << cfg_rate);
        check(mism_rx == 0, "R7", {tag, " receive bytes"}, rx_act, rx_exp_v);
    endtask

    task automatic test_reset();
        rst_n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(txd_oe == 0 && txd_o == 0, "R9", "reset txd", {txd_oe, txd_o}, 0);
        check(req_valid == 0, "R9", "reset req_valid", req_valid, 0);
        check(rx_valid == 0, "R9", "reset rx_valid", rx_valid, 0);
        @(posedge clk); rst_n = 1;
        begin
            int seen = 0;
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                if (txd_oe) seen++;
            end
            // R9: nothing staged yet for the first slot
            check(seen == 0, "R9", "oe before first staged byte", seen, 0);
        end
    endtask

    task automatic test_top_rate();
        run_case(3, 1, 0, 0, 1, 1);   // R1 R4: rate 3 drops offset[0]
        check_common("rate3 alt-oe");
    endtask

    task automatic test_low_rate_offset();
        run_case(0, 5 * 32 + 3 * 4 + 1, 0, 0, 3, 2);   // R3 quarter honoured
        check_common("rate0 offset");
    endtask

    task automatic test_half_res();
        run_case(2, 2 * 32 + 7 * 4 + 1, 1, 0, 0, 3);   // R4 slow clock: half bit
        check_common("rate2 slow half-res");
    endtask

    task automatic test_quarter_res();
        run_case(2, 2 * 32 + 7 * 4 + 1, 0, 0, 0, 3);   // R4 fast clock: quarter bit
        check_common("rate2 fast quarter-res");
    endtask

    task automatic test_wrap_no_oe();
        run_case(1, 300 * 32 + 4 * 4 + 3, 0, 0, 2, 4);   // R3 slot wrap, R6 all disabled
        check_common("rate1 wrap no-oe");
    endtask

    task automatic test_bidir();
        run_case(2, 10, 0, 1, 1, 5);
        check_common("bidir");
        // R8: only undriven slots return bytes, from the shared line
        check(rx_cnt == 64, "R8", "bidir byte count", rx_cnt, 64);
    endtask

    initial begin
        test_reset();
        test_top_rate();
        test_low_rate_offset();
        test_half_res();
        test_quarter_res();
        test_wrap_no_oe();
        test_bidir();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(190000 * 8);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule